// File: doc/BRIEF.md
# Chained Instruction Watchpoint Pair

This block holds two hardware watchpoint units that watch the instruction fetch stream. Each unit keeps an address value with a per-bit address mask, and a control value with a per-bit control mask. On every fetch strobe the unit checks the fetch address and a small set of fetch attributes against these values: the instruction-set state (compressed or normal width), the privilege of the access, and its own external condition input. Each unit also checks two coupling inputs. A mask bit of 1 makes the matching bit a don't-care.

Unit 1 is wired into unit 0 in two ways. Its chain latch sets when unit 1 hits and stays set until unit 1's control value is rewritten or reset is applied. Unit 0 compares this latched chain signal, so it can break on an address only after unit 1 has seen a given fetch. Unit 1's hit in the current fetch also drives unit 0's range input, so both units can be required to match the same fetch. An example is an address window that unit 1 defines.

A unit raises the breakpoint only when it hits and its enable bit is set. The enable bit has no mask. The single breakpoint request is registered and appears in the cycle after the fetch strobe. Software loads all registers through a simple write port.

Top module: `wpc_pair`

## Requirements
- R1: After reset, or while `trst_n` is low, all value and mask registers are zero, the chain latch is clear and `ibrk_req` is low.
- R2: The address field matches when, for every bit, the address mask bit is 1 or `fetch_addr` equals the address value bit.
- R3: `ibrk_req` is high in the cycle after a fetch strobe in which an enabled unit matched. It is low after a cycle with `fetch_valid` low.
- R4: Control bit 3 is compared with `fetch_priv`. A value of 1 selects privileged fetches and 0 selects user fetches.
- R5: Control bit 8 is compared with `fetch_cmp`. A value of 1 selects compressed-instruction fetches and 0 selects normal-width fetches.
- R6: Control bit 4 of unit u is compared with `ext_cond[u]`.
- R7: Unit 1's chain latch sets when unit 1 matches, whatever its enable. It clears when unit 1's control value is written or on reset. Unit 0 compares its control bit 5 with this latch. Unit 1's own chain input is 0.
- R8: Unit 0 compares its control bit 6 with unit 1's match in the same fetch. Unit 1's own range input is 0.
- R9: A unit raises a request only if control bit 7 (enable) is 1. Control mask bit 7 has no effect.
- R10: Control value bits 2:0 and control mask bits 2:0 have no effect on matching.
- R11: `cfg_sel[2]` picks the unit and `cfg_sel[1:0]` picks the register: 0 is the address value, 1 the address mask, 2 the control value, 3 the control mask. The control registers take `cfg_wdata[8:0]`. A write touches only the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| trst_n | input | 1 | Active-low asynchronous test reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Unit (bit 2) and register (bits 1:0) select |
| cfg_wdata | input | ADDR_W | Register write data |
| fetch_valid | input | 1 | Fetch strobe |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_cmp | input | 1 | Fetch is in compressed-instruction state |
| fetch_priv | input | 1 | Fetch is privileged |
| ext_cond | input | 2 | External condition, one bit per unit |
| ibrk_req | output | 1 | Registered instruction-breakpoint request |

## Verification
The bench builds the block with the default `ADDR_W` of 32. All control positions and both units are therefore present. Wide address masks of 12 and 8 low bits let one unit cover a window and the other a sub-window, which puts the range coupling within reach. A behavioural model recomputes the request on every clock, including the chain latch's history across control writes and a mid-run reset.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int CTRL_W = 9;
  localparam logic [CTRL_W-1:0] CMP_SET = 9'b1_0111_1000;

  typedef enum logic [1:0] {
    SEL_AVAL = 2'd0,
    SEL_AMSK = 2'd1,
    SEL_CVAL = 2'd2,
    SEL_CMSK = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       cmp;
    logic       en;
    logic       rng;
    logic       chn;
    logic       ext;
    logic       priv;
    logic [2:0] rsv;
  } ctrl_t;

  function automatic ctrl_t build_obs(logic cmp, logic priv, logic ext,
                                      logic chn, logic rng);
    ctrl_t o;
    o      = '0;
    o.cmp  = cmp;
    o.priv = priv;
    o.ext  = ext;
    o.chn  = chn;
    o.rng  = rng;
    return o;
  endfunction

  function automatic logic ctrl_fits(ctrl_t v, ctrl_t m, ctrl_t o);
    logic [CTRL_W-1:0] ok;
    ok = ~CMP_SET | m | ~(v ^ o);
    return &ok;
  endfunction
endpackage

// File: rtl/wpc_cmp.sv
module wpc_cmp
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] aval,
  input  logic [ADDR_W-1:0] amsk,
  input  ctrl_t             cval,
  input  ctrl_t             cmsk,
  input  ctrl_t             obs,
  output logic              addr_ok,
  output logic              ctrl_ok
);
  function automatic logic addr_fits(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] v,
                                     logic [ADDR_W-1:0] m);
    return &(m | ~(a ^ v));
  endfunction

  assign addr_ok = addr_fits(fetch_addr, aval, amsk);
  assign ctrl_ok = ctrl_fits(cval, cmsk, obs);
endmodule

// File: rtl/wpc_unit.sv
module wpc_unit
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              trst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_cmp,
  input  logic              fetch_priv,
  input  logic              ext_in,
  input  logic              chain_in,
  input  logic              range_in,
  output logic              hit,
  output logic              armed,
  output logic              enabled,
  output logic              chain_out
);
  logic [ADDR_W-1:0] aval, amsk;
  ctrl_t             cval, cmsk, obs;
  logic              addr_ok, ctrl_ok, cval_wr, data_ok, chain_q;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(wr_sel);
  assign cval_wr = wr_en && (sel == SEL_CVAL);

  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n) begin
      aval <= '0;
      amsk <= '0;
      cval <= '0;
      cmsk <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_AVAL: aval <= wr_data;
        SEL_AMSK: amsk <= wr_data;
        SEL_CVAL: cval <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default:  cmsk <= ctrl_t'(wr_data[CTRL_W-1:0]);
      endcase
    end
  end

  assign obs = build_obs(fetch_cmp, fetch_priv, ext_in, chain_in, range_in);

  wpc_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .fetch_addr (fetch_addr),
    .aval       (aval),
    .amsk       (amsk),
    .cval       (cval),
    .cmsk       (cmsk),
    .obs        (obs),
    .addr_ok    (addr_ok),
    .ctrl_ok    (ctrl_ok)
  );

  assign hit     = fetch_valid && addr_ok && ctrl_ok;
  assign enabled = cval.en;
  assign armed   = hit && cval.en;
  // no instruction data field is compared, so its result is always true
  assign data_ok = 1'b1;

  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n)      chain_q <= 1'b0;
    else if (cval_wr) chain_q <= 1'b0;
    else if (hit)     chain_q <= data_ok;
  end
  assign chain_out = chain_q;

  // R7: a control value write leaves the chain latch clear
  a_r7_chain_clear: assert property (@(posedge clk) disable iff (!trst_n)
    cval_wr |=> !chain_q);
  // R7: the latch only sets on a match
  a_r7_chain_set_on_hit: assert property (@(posedge clk) disable iff (!trst_n)
    $rose(chain_q) |-> $past(hit));
  // R8: a required range bit needs the partner's match
  a_r8_range_needs_partner: assert property (@(posedge clk) disable iff (!trst_n)
    (hit && cval.rng && !cmsk.rng) |-> range_in);
  // R6: an unmasked external bit must agree with the input
  a_r6_ext_agrees: assert property (@(posedge clk) disable iff (!trst_n)
    (hit && !cmsk.ext) |-> (ext_in == cval.ext));
endmodule

// File: rtl/wpc_pair.sv
module wpc_pair #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              trst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_cmp,
  input  logic              fetch_priv,
  input  logic [1:0]        ext_cond,
  output logic              ibrk_req
);
  localparam int NUNITS = 2;

  logic [NUNITS-1:0] hit_w, armed_w, en_w, chain_w;
  logic              brk_q;

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    logic chain_src, range_src;
    if (u == 0) begin : g_head
      assign chain_src = chain_w[1];
      assign range_src = hit_w[1];
    end else begin : g_tail
      assign chain_src = 1'b0;
      assign range_src = 1'b0;
    end

    wpc_unit #(.ADDR_W(ADDR_W)) u_wp (
      .clk         (clk),
      .trst_n      (trst_n),
      .wr_en       (cfg_we && (cfg_sel[2] == u[0])),
      .wr_sel      (cfg_sel[1:0]),
      .wr_data     (cfg_wdata),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .fetch_cmp   (fetch_cmp),
      .fetch_priv  (fetch_priv),
      .ext_in      (ext_cond[u]),
      .chain_in    (chain_src),
      .range_in    (range_src),
      .hit         (hit_w[u]),
      .armed       (armed_w[u]),
      .enabled     (en_w[u]),
      .chain_out   (chain_w[u])
    );
  end

  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n) brk_q <= 1'b0;
    else         brk_q <= |armed_w;
  end
  assign ibrk_req = brk_q;

  // R3: a request follows a fetch strobe
  a_r3_needs_strobe: assert property (@(posedge clk) disable iff (!trst_n)
    ibrk_req |-> $past(fetch_valid));
  // R9: a request needs some unit enabled in the fetch cycle
  a_r9_needs_enable: assert property (@(posedge clk) disable iff (!trst_n)
    ibrk_req |-> $past(en_w != '0));
  // R7: unit 0's own latch also clears on its control value write
  a_r7_unit0_latch_clear: assert property (@(posedge clk) disable iff (!trst_n)
    (cfg_we && cfg_sel == 3'b010) |=> !chain_w[0]);
endmodule

// File: tb/wpc_pair_tb.sv
module wpc_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] C_PRIV = 9'h008, C_EXT = 9'h010, C_CHN = 9'h020,
                         C_RNG = 9'h040, C_EN = 9'h080, C_CMP = 9'h100;

  logic        clk = 0, trst_n = 0, cfg_we = 0, fetch_valid = 0;
  logic        fetch_cmp = 0, fetch_priv = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, fetch_addr = 0;
  logic [1:0]  ext_cond = 0;
  logic        ibrk_req;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  wpc_pair #(.ADDR_W(32)) u_dut (
    .clk(clk), .trst_n(trst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_cmp(fetch_cmp), .fetch_priv(fetch_priv), .ext_cond(ext_cond),
    .ibrk_req(ibrk_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_av[2], m_am[2];
  logic [8:0]  m_cv[2], m_cm[2];
  bit          m_chain, m_brk;

  function automatic bit m_hit(int u, logic [31:0] a, bit c, bit p, bit e, bit ch, bit rg);
    for (int i = 0; i < 32; i++)
      if (!m_am[u][i] && a[i] !== m_av[u][i]) return 0;
    if (!m_cm[u][3] && m_cv[u][3] != p)  return 0;
    if (!m_cm[u][4] && m_cv[u][4] != e)  return 0;
    if (!m_cm[u][5] && m_cv[u][5] != ch) return 0;
    if (!m_cm[u][6] && m_cv[u][6] != rg) return 0;
    if (!m_cm[u][8] && m_cv[u][8] != c)  return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge trst_n) begin
    if (!trst_n) begin
      for (int u = 0; u < 2; u++) begin
        m_av[u] = 0; m_am[u] = 0; m_cv[u] = 0; m_cm[u] = 0;
      end
      m_chain = 0; m_brk = 0;
    end else begin
      bit h0, h1;
      h1 = fetch_valid && m_hit(1, fetch_addr, fetch_cmp, fetch_priv, ext_cond[1], 0, 0);
      h0 = fetch_valid && m_hit(0, fetch_addr, fetch_cmp, fetch_priv, ext_cond[0], m_chain, h1);
      m_brk = (h0 && m_cv[0][7]) || (h1 && m_cv[1][7]);
      if (cfg_we && cfg_sel == 3'b110) m_chain = 0;
      else if (h1) m_chain = 1;
      if (cfg_we) begin
        case (cfg_sel[1:0])
          2'd0: m_av[cfg_sel[2]] = cfg_wdata;
          2'd1: m_am[cfg_sel[2]] = cfg_wdata;
          2'd2: m_cv[cfg_sel[2]] = cfg_wdata[8:0];
          default: m_cm[cfg_sel[2]] = cfg_wdata[8:0];
        endcase
      end
    end
  end

  task automatic chk(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ibrk_req=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (trst_n && !done) chk(ibrk_req, m_brk, {cur_req, " model"});

  task automatic wr(bit u, logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = {u, sel}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fetch(bit v, logic [31:0] a, bit c, bit p, logic [1:0] e, bit exp, string tag);
    @(negedge clk);
    cur_req = tag;
    fetch_valid = v; fetch_addr = a; fetch_cmp = c; fetch_priv = p; ext_cond = e;
    @(negedge clk);
    fetch_valid = 0;
    chk(ibrk_req, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ibrk_req, 0, "R1 reset");
    trst_n = 1;
    // unit 0: address 0x100, privileged, normal width
    wr(0, 2'd0, 32'h100); wr(0, 2'd1, 0);
    wr(0, 2'd3, C_EXT | C_CHN | C_RNG); wr(0, 2'd2, C_EN | C_PRIV);
    fetch(1, 32'h100, 0, 1, 0, 1, "R2");
    fetch(1, 32'h104, 0, 1, 0, 0, "R2");
    fetch(0, 32'h100, 0, 1, 0, 0, "R3");
    fetch(1, 32'h100, 0, 0, 0, 0, "R4");
    fetch(1, 32'h100, 1, 1, 0, 0, "R5");
    wr(0, 2'd1, 32'hF);
    fetch(1, 32'h10C, 0, 1, 0, 1, "R2");
    fetch(1, 32'h11C, 0, 1, 0, 0, "R2");
    // R10: low control bits are ignored
    wr(0, 2'd2, C_EN | C_PRIV | 9'h7);
    fetch(1, 32'h100, 0, 1, 0, 1, "R10");
    wr(0, 2'd3, C_EXT | C_CHN | C_RNG | 9'h7);
    fetch(1, 32'h100, 0, 1, 0, 1, "R10");
    // R9: enable needed, enable mask has no effect
    wr(0, 2'd3, C_EXT | C_CHN | C_RNG | C_EN); wr(0, 2'd2, C_PRIV);
    fetch(1, 32'h100, 0, 1, 0, 0, "R9");
    wr(0, 2'd3, C_EXT | C_CHN | C_RNG);
    // R4: user selection
    wr(0, 2'd2, C_EN);
    fetch(1, 32'h100, 0, 0, 0, 1, "R4");
    fetch(1, 32'h100, 0, 1, 0, 0, "R4");
    // R5: compressed selection
    wr(0, 2'd2, C_EN | C_CMP | C_PRIV);
    fetch(1, 32'h100, 1, 1, 0, 1, "R5");
    fetch(1, 32'h100, 0, 1, 0, 0, "R5");
    // R6, R11: unit 1 with external condition
    wr(1, 2'd0, 32'h300); wr(1, 2'd1, 0); wr(1, 2'd3, 0);
    fetch(1, 32'h100, 1, 1, 0, 1, "R11");
    wr(1, 2'd2, C_EN | C_EXT | C_PRIV);
    fetch(1, 32'h300, 0, 1, 2'b10, 1, "R6");
    fetch(1, 32'h300, 0, 1, 2'b01, 0, "R6");
    wr(1, 2'd3, C_EXT);
    fetch(1, 32'h300, 0, 1, 2'b00, 1, "R6");
    // R7: chain from unit 1 into unit 0
    wr(1, 2'd2, C_PRIV);
    wr(0, 2'd3, C_EXT | C_RNG); wr(0, 2'd2, C_EN | C_PRIV | C_CHN);
    fetch(1, 32'h100, 0, 1, 0, 0, "R7");
    fetch(1, 32'h300, 0, 1, 0, 0, "R7");
    fetch(1, 32'h100, 0, 1, 0, 1, "R7");
    fetch(1, 32'h100, 0, 1, 0, 1, "R7");
    wr(1, 2'd2, C_PRIV);
    fetch(1, 32'h100, 0, 1, 0, 0, "R7");
    fetch(1, 32'h300, 0, 1, 0, 0, "R7");
    wr(1, 2'd0, 32'h300);
    fetch(1, 32'h100, 0, 1, 0, 1, "R7");
    // R8: range coupling, unit 1 window inside unit 0 window
    wr(0, 2'd1, 32'hFFF); wr(0, 2'd3, C_EXT | C_CHN);
    wr(0, 2'd2, C_EN | C_PRIV | C_RNG);
    wr(1, 2'd1, 32'hFF);
    fetch(1, 32'h320, 0, 1, 0, 1, "R8");
    fetch(1, 32'h120, 0, 1, 0, 0, "R8");
    fetch(1, 32'h1320, 0, 1, 0, 0, "R8");
    // R1: reset mid-run clears everything
    @(negedge clk); trst_n = 0;
    repeat (2) @(negedge clk);
    chk(ibrk_req, 0, "R1");
    trst_n = 1;
    fetch(1, 32'h0, 0, 0, 0, 0, "R1");
    wr(0, 2'd3, C_RNG | C_CHN); wr(0, 2'd2, C_EN);
    fetch(1, 32'h0, 0, 0, 0, 1, "R1");
    fetch(1, 32'h4, 0, 0, 0, 0, "R1");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule